// File: doc/BRIEF.md
# Address-Event Packet Merge Relay

This block carries spike traffic rightward along a one-dimensional chain of chips. It has two inputs. The first takes word-serial bursts from the local neuron array: a row-address word followed by one or more column-address words, with a last-word marker on the final word. The second takes packets from the upstream neighbour. Both inputs feed one downstream output. All three ports are valid/ready word streams.

A local burst leaves with a new head word in front of it. That head word is all zero, so its chip-address field is zero. An upstream packet keeps every word, but the chip-address field of its head word goes up by one. Each receiver therefore sees the sender's position counted relative to itself. A two-way arbiter grants whole packets and never splits one. Ties alternate between the two sources. A word queue on the upstream port absorbs neighbour traffic while a local packet owns the output.

Top module: `aer_merge_relay`

## Requirements
- R1: A local burst {row, col...} leaves as {0, row, col...}: one inserted all-zero head word, then the burst words unchanged and in order. For example, row 32 with the single column 127 leaves as {0, 32, 127}.
- R2: For an upstream packet, the output head word keeps bits 7:6 of the incoming head (the delivery bit and the mode bit). Bits 5:0 of the head, the chip address, are incremented by one. All other words pass unchanged.
- R3: A chip-address field of 63 (all ones) wraps to 0 on increment, and bits 7:6 are left as they were.
- R4: The words of one packet leave contiguously, in order. No word of the other source appears between a packet's head and its last word.
- R5: When both sources have packets waiting, the granted source alternates packet by packet.
- R6: While the output is stalled, the upstream port accepts exactly DEPTH+2 words (DEPTH queued plus two in flight) before it deasserts up_ready. No accepted word is lost or reordered.
- R7: out_head is 1 on the first word of every output packet and 0 otherwise. out_last is 1 only on the final word. For a local burst this is the final burst word, never the inserted head.
- R8: While out_valid is 1 and out_ready is 0, out_data, out_head and out_last hold their values.
- R9: After reset, out_valid is 0 and up_ready is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| loc_valid | input | 1 | Local burst word valid |
| loc_data | input | W | Local row or column address |
| loc_last | input | 1 | Final word of the local burst |
| loc_ready | output | 1 | Local word accepted |
| up_valid | input | 1 | Upstream word valid |
| up_data | input | W | Upstream packet word |
| up_last | input | 1 | Final word of the upstream packet |
| up_ready | output | 1 | Upstream queue has room |
| out_valid | output | 1 | Output word valid |
| out_data | output | W | Output word |
| out_head | output | 1 | Output word is a packet head |
| out_last | output | 1 | Output word ends a packet |
| out_ready | input | 1 | Downstream accepts the output word |

## Verification
Two functions can fall in the same cycle.

- **Arbitration and insertion.** A local head insertion and an upstream head increment can both compete for the output grant. The bench provokes this by holding the output stalled while both sources load several packets, then draining with an irregular ready pattern. It judges the result by attributing each output packet to its source word by word, and by requiring the source order to alternate.
- **Queue fill and stall.** Filling the queue under a stalled output must coincide with a frozen output word. The bench counts the accepted words against DEPTH+2 and re-reads the held word.

// File: rtl/aer_relay_pkg.sv
package aer_relay_pkg;
  typedef enum logic {
    SRC_LOC = 1'b0,
    SRC_UP  = 1'b1
  } src_e;

  // number of reserved flag bits at the top of a head word
  localparam int RSV_BITS = 2;
endpackage

// File: rtl/aer_up_fifo.sv
module aer_up_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 64
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_valid,
  input  logic [W-1:0] wr_data,
  input  logic         wr_last,
  output logic         wr_ready,
  output logic         rd_valid,
  output logic [W-1:0] rd_data,
  output logic         rd_last,
  input  logic         rd_ready
);
  localparam int AW = $clog2(DEPTH);
  localparam logic [AW:0] FULL = DEPTH;

  logic [W:0]    mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [AW:0]   cnt;
  logic [W:0]    q;
  logic          push, fetch;

  assign wr_ready = (cnt != FULL);
  assign push     = wr_valid && wr_ready;
  assign fetch    = (cnt != '0) && (!rd_valid || rd_ready);

  // storage without reset so it maps onto block RAM
  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= {wr_last, wr_data};
    if (fetch) q <= mem[rd_ptr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr   <= '0;
      rd_ptr   <= '0;
      cnt      <= '0;
      rd_valid <= 1'b0;
    end else begin
      if (push) wr_ptr <= wr_ptr + 1'b1;
      if (fetch) rd_ptr <= rd_ptr + 1'b1;
      case ({push, fetch})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
      if (fetch) rd_valid <= 1'b1;
      else if (rd_ready) rd_valid <= 1'b0;
    end
  end

  assign rd_data = q[W-1:0];
  assign rd_last = q[W];
endmodule

// File: rtl/aer_head_bump.sv
module aer_head_bump #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  input  logic [W-1:0] in_data,
  input  logic         in_last,
  output logic         in_ready,
  output logic         out_valid,
  output logic [W-1:0] out_data,
  output logic         out_head,
  output logic         out_last,
  input  logic         out_ready
);
  import aer_relay_pkg::*;
  localparam int AD = W - RSV_BITS;
  localparam logic [AD-1:0] ONE = 1;

  logic at_head;

  assign out_valid = in_valid;
  assign in_ready  = out_ready;
  assign out_head  = at_head;
  assign out_last  = in_last;
  assign out_data  = at_head ? {in_data[W-1:AD], in_data[AD-1:0] + ONE} : in_data;

  always_ff @(posedge clk) begin
    if (rst) at_head <= 1'b1;
    else if (in_valid && out_ready) at_head <= in_last;
  end
endmodule

// File: rtl/aer_head_insert.sv
module aer_head_insert #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         loc_valid,
  input  logic [W-1:0] loc_data,
  input  logic         loc_last,
  output logic         loc_ready,
  output logic         out_valid,
  output logic [W-1:0] out_data,
  output logic         out_head,
  output logic         out_last,
  input  logic         out_ready
);
  logic pend;   // next output word is the inserted head

  assign out_valid = loc_valid;
  assign out_data  = pend ? '0 : loc_data;
  assign out_head  = pend;
  assign out_last  = !pend && loc_last;
  assign loc_ready = out_ready && !pend;

  always_ff @(posedge clk) begin
    if (rst) pend <= 1'b1;
    else if (loc_valid && out_ready) begin
      if (pend) pend <= 1'b0;
      else if (loc_last) pend <= 1'b1;
    end
  end
endmodule

// File: rtl/aer_pkt_arb.sv
module aer_pkt_arb #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         a_valid,
  input  logic [W-1:0] a_data,
  input  logic         a_head,
  input  logic         a_last,
  output logic         a_ready,
  input  logic         b_valid,
  input  logic [W-1:0] b_data,
  input  logic         b_head,
  input  logic         b_last,
  output logic         b_ready,
  output logic         o_valid,
  output logic [W-1:0] o_data,
  output logic         o_head,
  output logic         o_last,
  input  logic         o_ready
);
  import aer_relay_pkg::*;

  logic locked;
  src_e owner, prio, choice, cur;
  logic take, xfer, w_last, w_head;
  logic [W-1:0] w_data;

  assign take = !o_valid || o_ready;

  always_comb begin
    if (a_valid && b_valid) choice = prio;
    else if (b_valid)       choice = SRC_UP;
    else                    choice = SRC_LOC;
    cur = locked ? owner : choice;
  end

  assign a_ready = take && (cur == SRC_LOC);
  assign b_ready = take && (cur == SRC_UP);
  assign xfer    = (a_valid && a_ready) || (b_valid && b_ready);
  assign w_data  = (cur == SRC_UP) ? b_data : a_data;
  assign w_head  = (cur == SRC_UP) ? b_head : a_head;
  assign w_last  = (cur == SRC_UP) ? b_last : a_last;

  always_ff @(posedge clk) begin
    if (rst) begin
      o_valid <= 1'b0;
      o_data  <= '0;
      o_head  <= 1'b0;
      o_last  <= 1'b0;
      locked  <= 1'b0;
      owner   <= SRC_LOC;
      prio    <= SRC_LOC;
    end else if (take) begin
      o_valid <= xfer;
      if (xfer) begin
        o_data <= w_data;
        o_head <= w_head;
        o_last <= w_last;
        if (w_last) begin
          locked <= 1'b0;
          prio   <= (cur == SRC_LOC) ? SRC_UP : SRC_LOC;
        end else begin
          locked <= 1'b1;
          owner  <= cur;
        end
      end
    end
  end
endmodule

// File: rtl/aer_merge_relay.sv
module aer_merge_relay #(
  parameter int W     = 8,
  parameter int DEPTH = 64
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         loc_valid,
  input  logic [W-1:0] loc_data,
  input  logic         loc_last,
  output logic         loc_ready,
  input  logic         up_valid,
  input  logic [W-1:0] up_data,
  input  logic         up_last,
  output logic         up_ready,
  output logic         out_valid,
  output logic [W-1:0] out_data,
  output logic         out_head,
  output logic         out_last,
  input  logic         out_ready
);
  logic         f_valid, f_last, f_ready;
  logic [W-1:0] f_data;
  logic         u_valid, u_head, u_last, u_ready;
  logic [W-1:0] u_data;
  logic         l_valid, l_head, l_last, l_ready;
  logic [W-1:0] l_data;

  aer_up_fifo #(.W(W), .DEPTH(DEPTH)) i_fifo (
    .clk(clk), .rst(rst),
    .wr_valid(up_valid), .wr_data(up_data), .wr_last(up_last), .wr_ready(up_ready),
    .rd_valid(f_valid), .rd_data(f_data), .rd_last(f_last), .rd_ready(f_ready)
  );

  aer_head_bump #(.W(W)) i_bump (
    .clk(clk), .rst(rst),
    .in_valid(f_valid), .in_data(f_data), .in_last(f_last), .in_ready(f_ready),
    .out_valid(u_valid), .out_data(u_data), .out_head(u_head), .out_last(u_last),
    .out_ready(u_ready)
  );

  aer_head_insert #(.W(W)) i_ins (
    .clk(clk), .rst(rst),
    .loc_valid(loc_valid), .loc_data(loc_data), .loc_last(loc_last), .loc_ready(loc_ready),
    .out_valid(l_valid), .out_data(l_data), .out_head(l_head), .out_last(l_last),
    .out_ready(l_ready)
  );

  aer_pkt_arb #(.W(W)) i_arb (
    .clk(clk), .rst(rst),
    .a_valid(l_valid), .a_data(l_data), .a_head(l_head), .a_last(l_last), .a_ready(l_ready),
    .b_valid(u_valid), .b_data(u_data), .b_head(u_head), .b_last(u_last), .b_ready(u_ready),
    .o_valid(out_valid), .o_data(out_data), .o_head(out_head), .o_last(out_last),
    .o_ready(out_ready)
  );
endmodule

// File: rtl/aer_merge_relay_chk.sv
module aer_merge_relay_chk #(
  parameter int W     = 8,
  parameter int DEPTH = 64
) (
  input logic         clk,
  input logic         rst,
  input logic         loc_valid,
  input logic [W-1:0] loc_data,
  input logic         loc_last,
  input logic         loc_ready,
  input logic         up_valid,
  input logic [W-1:0] up_data,
  input logic         up_last,
  input logic         up_ready,
  input logic         out_valid,
  input logic [W-1:0] out_data,
  input logic         out_head,
  input logic         out_last,
  input logic         out_ready
);
  logic open_pkt;

  always_ff @(posedge clk) begin
    if (rst) open_pkt <= 1'b0;
    else if (out_valid && out_ready) open_pkt <= !out_last;
  end

  a_r8_hold_stable: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_head) && $stable(out_last));

  a_r4_head_opens: assert property (@(posedge clk) disable iff (rst)
    out_valid && !open_pkt |-> out_head);

  a_r4_no_head_inside: assert property (@(posedge clk) disable iff (rst)
    out_valid && open_pkt |-> !out_head);

  a_r9_reset_idle: assert property (@(posedge clk)
    rst |=> !out_valid);

  a_r1_local_forwarded: assert property (@(posedge clk) disable iff (rst)
    loc_valid && loc_ready |=> out_valid);
endmodule

bind aer_merge_relay aer_merge_relay_chk #(.W(W), .DEPTH(DEPTH)) i_chk (.*);

// File: tb/test_aer_merge_relay.sv
module test_aer_merge_relay;
  localparam int W = 8;
  localparam int DEPTH = 64;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic loc_valid = 0, loc_last = 0, up_valid = 0, up_last = 0, out_ready = 0;
  logic [W-1:0] loc_data = '0, up_data = '0;
  logic loc_ready, up_ready, out_valid, out_head, out_last;
  logic [W-1:0] out_data;

  aer_merge_relay #(.W(W), .DEPTH(DEPTH)) i_aer_merge_relay (.*);

  int total = 0, bad = 0;
  logic [W+1:0] exp_loc[$], exp_up[$];   // {head,last,data}
  logic [W:0]   in_loc[$], in_up[$];     // {last,data}
  int pkt_src[$];
  int cur_src = -1;
  int up_taken = 0;
  int rdy_mode = 0;
  int cyc = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic push_local(input int row, input int ncol, input int base);
    logic [W-1:0] r, c;
    r = row[W-1:0];
    in_loc.push_back({1'b0, r});
    exp_loc.push_back({1'b1, 1'b0, {W{1'b0}}});
    exp_loc.push_back({1'b0, 1'b0, r});
    for (int k = 0; k < ncol; k++) begin
      c = W'((base + 17 * k) % 256);
      in_loc.push_back({k == ncol - 1, c});
      exp_loc.push_back({1'b0, k == ncol - 1, c});
    end
  endtask

  task automatic push_up(input logic [W-1:0] head, input int nd, input int base);
    logic [W-1:0] d;
    logic [5:0] a;
    a = head[5:0] + 6'd1;
    in_up.push_back({nd == 0, head});
    exp_up.push_back({1'b1, nd == 0, head[7:6], a});
    for (int k = 0; k < nd; k++) begin
      d = W'((base * 3 + k * 29) % 256);
      in_up.push_back({k == nd - 1, d});
      exp_up.push_back({1'b0, k == nd - 1, d});
    end
  endtask

  // drive inputs away from the active edge
  always @(negedge clk) begin
    cyc++;
    loc_valid = !rst && in_loc.size() > 0;
    if (in_loc.size() > 0) {loc_last, loc_data} = in_loc[0];
    up_valid = !rst && in_up.size() > 0;
    if (in_up.size() > 0) {up_last, up_data} = in_up[0];
    case (rdy_mode)
      0: out_ready = 1'b1;
      1: out_ready = 1'b0;
      default: out_ready = (cyc % 3) != 0;
    endcase
  end

  // sample shortly before each rising edge
  initial forever begin
    logic [W+1:0] got, e;
    int src;
    @(negedge clk);
    #4;
    if (!rst) begin
      if (loc_valid && loc_ready) void'(in_loc.pop_front());
      if (up_valid && up_ready) begin
        void'(in_up.pop_front());
        up_taken++;
      end
      if (out_valid && out_ready) begin
        got = {out_head, out_last, out_data};
        if (out_head) begin
          if (exp_up.size() == 0) src = 0;
          else if (exp_loc.size() == 0) src = 1;
          else src = (out_data == 0) ? 0 : 1;
          cur_src = src;
          pkt_src.push_back(src);
        end
        if (cur_src == 0 && exp_loc.size() > 0) begin
          e = exp_loc.pop_front();
          check(got == e, "R1 R4 R7 local word", int'(got), int'(e));
        end else if (cur_src == 1 && exp_up.size() > 0) begin
          e = exp_up.pop_front();
          check(got == e, "R2 R3 R4 R7 upstream word", int'(got), int'(e));
        end else begin
          check(1'b0, "R4 unexpected word", int'(got), -1);
        end
        if (out_last) cur_src = -1;
      end
    end
  end

  task automatic drain(input string req);
    int i;
    i = 0;
    while (i < 8000 && (exp_loc.size() > 0 || exp_up.size() > 0 || in_loc.size() > 0 || in_up.size() > 0)) begin
      @(posedge clk);
      i++;
    end
    check(exp_loc.size() == 0 && exp_up.size() == 0, req, exp_loc.size() + exp_up.size(), 0);
  endtask

  initial begin
    #(200000 * 10);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=%0d expected=0", 1);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int n0, t0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    #4;
    check(out_valid == 1'b0, "R9 out_valid after reset", int'(out_valid), 0);
    check(up_ready == 1'b1, "R9 up_ready after reset", int'(up_ready), 1);
    @(negedge clk);
    rst = 1'b0;

    // R1 worked example: row 32, column 127
    push_local(32, 1, 127);
    drain("R1 example drained");

    // local bursts of 1..8 columns
    for (int n = 1; n <= 8; n++) push_local(n * 9, n, n * 31);
    drain("R1 R7 local sweep drained");

    // every head value, packet lengths 1..3 words (R2, R3 wrap cases included)
    for (int h = 0; h < 256; h++) push_up(W'(h), h % 3, h);
    drain("R2 R3 head sweep drained");

    // R6/R8: stalled output fills the upstream queue
    rdy_mode = 1;
    t0 = up_taken;
    for (int k = 0; k < 20; k++) push_up(8'h40 | W'(k), 3, k);
    repeat (150) @(posedge clk);
    @(negedge clk);
    #4;
    check(up_taken - t0 == DEPTH + 2, "R6 words accepted while stalled", up_taken - t0, DEPTH + 2);
    check(up_ready == 1'b0, "R6 up_ready when full", int'(up_ready), 0);
    check(out_valid && out_data == 8'h41, "R8 held word", int'(out_data), 8'h41);
    repeat (10) @(posedge clk);
    @(negedge clk);
    #4;
    check(out_valid && out_data == 8'h41 && out_head, "R8 held word later", int'(out_data), 8'h41);
    rdy_mode = 0;
    drain("R6 queued words drained in order");

    // R4/R5: both sources backlogged, irregular downstream ready
    rdy_mode = 1;
    n0 = pkt_src.size();
    for (int k = 0; k < 4; k++) begin
      push_local(10 + k, k + 1, 50 + k);
      push_up(8'h85, k + 1, 70 + k);
    end
    repeat (30) @(posedge clk);
    rdy_mode = 2;
    drain("R4 contention drained");
    rdy_mode = 0;
    check(pkt_src.size() - n0 == 8, "R5 packet count", pkt_src.size() - n0, 8);
    if (pkt_src.size() - n0 == 8)
      for (int i = 1; i < 8; i++)
        check(pkt_src[n0 + i] != pkt_src[n0 + i - 1], "R5 alternation", pkt_src[n0 + i], 1 - pkt_src[n0 + i - 1]);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule